// File: doc/BRIEF.md
# Interrupt priority mask controller

This block decides which maskable interrupt request is passed to the processor. It serves a timer source and two DMA channel sources. Each source has a control register that holds a 3-bit priority and a mask bit. A separate shared mask register gives a second view of the same mask bits. A global threshold register sets the least urgent priority that may still raise an interrupt. An in-service register records the sources the processor is handling.

On each cycle the block finds the unmasked requests that pass the threshold. It also requires each candidate to be more urgent than every source already in service. From those, it picks one winner and drives a registered interrupt request together with the winner's source number. An acknowledge strobe marks the presented source as in service. An end-of-interrupt strobe that names a source clears that source's in-service bit.

Top module: `ipm_ctrl`

## Requirements
- R1: After reset the threshold register reads 0x0007, every control register reads 0x0007 (priority 7, mask bit 3 clear), the shared mask and in-service registers read 0, and `irq_o` is 0.
- R2: Only bits [2:0] of the threshold register (address 5) are stored. Bits [15:3] always read 0.
- R3: A request whose priority is numerically greater than the threshold is blocked. A request whose priority equals the threshold is forwarded.
- R4: Bit 3 of control register i (address i) and bit i of the shared mask register (address 4) are the same storage. A write through either view shows in both. A set mask bit blocks that source's request.
- R5: Among eligible requests, the one with the lowest priority number is presented.
- R6: Priority ties go to the lowest source number: timer 0 is source 0, DMA 0 is source 1, DMA 1 is source 2.
- R7: `ack_i` while `irq_o` is 1 sets in-service bit `irq_src_o` of the in-service register (address 6, bit i = source i). `ack_i` while `irq_o` is 0 changes nothing.
- R8: `eoi_i` clears the in-service bit of source `eoi_src_i`.
- R9: A request is blocked unless its priority number is strictly lower than that of every source in service.
- R10: `irq_o` and `irq_src_o` are registered. They change on the first clock edge after a request input changes, and `irq_src_o` is 0 while `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Request lines, bit i = source i |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i`, combinational |
| ack_i | input | 1 | CPU acknowledge of the presented source |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_src_i | input | 2 | Source number cleared by `eoi_i` |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_src_o | output | 2 | Source number of the presented request |

## Verification
The case that is hardest to reach from the ports is a blocked request caused by an in-service source whose priority equals the new request's priority. To reach it, the stimulus first drives one source, acknowledges it so that its bit is set, and drops its request. It then raises a different source at the same priority and checks that nothing is presented. Next it lowers that source's priority number by one and checks that the request now gets through. The acknowledge-with-no-request case is covered by pulsing `ack_i` while `irq_o` is low and then reading the in-service register back.

// File: rtl/ipm_pkg.sv
package ipm_pkg;
  localparam int PRI_W  = 3;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  typedef logic [PRI_W-1:0] pri_t;

  localparam logic [ADDR_W-1:0] ADDR_MASK = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_THR  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_ISR  = 3'd6;
  localparam int                CTRL_MSK  = 3;
  localparam pri_t              PRI_LOW   = 3'b111;
endpackage

// File: rtl/ipm_regs.sv
module ipm_regs
  import ipm_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          we_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NUM_SRC-1:0]            isr_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NUM_SRC-1:0][PRI_W-1:0] pri_o,
  output logic [NUM_SRC-1:0]            mask_o,
  output pri_t                          thr_o
);
  logic [NUM_SRC-1:0][PRI_W-1:0] pri_q;
  logic [NUM_SRC-1:0]            mask_q;
  pri_t                          thr_q;

  // Both mask views share one flop per source.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SRC; i++) pri_q[i] <= PRI_LOW;
      mask_q <= '0;
      thr_q  <= PRI_LOW;
    end else if (we_i) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (addr_i == ADDR_W'(i)) begin
          pri_q[i]  <= wdata_i[PRI_W-1:0];
          mask_q[i] <= wdata_i[CTRL_MSK];
        end
      end
      if (addr_i == ADDR_MASK) mask_q <= wdata_i[NUM_SRC-1:0];
      if (addr_i == ADDR_THR)  thr_q  <= wdata_i[PRI_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (addr_i == ADDR_W'(i)) begin
        rdata_o[PRI_W-1:0] = pri_q[i];
        rdata_o[CTRL_MSK]  = mask_q[i];
      end
    end
    if (addr_i == ADDR_MASK) rdata_o[NUM_SRC-1:0] = mask_q;
    if (addr_i == ADDR_THR)  rdata_o[PRI_W-1:0]   = thr_q;
    if (addr_i == ADDR_ISR)  rdata_o[NUM_SRC-1:0] = isr_i;
  end

  assign pri_o  = pri_q;
  assign mask_o = mask_q;
  assign thr_o  = thr_q;

  assert_thr_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_THR) |-> (rdata_o[DATA_W-1:PRI_W] == '0));

  assert_mask_view_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_MASK) |=> (mask_o == $past(wdata_i[NUM_SRC-1:0])));
endmodule

// File: rtl/ipm_inservice.sv
module ipm_inservice
  import ipm_pkg::*;
#(
  parameter int NUM_SRC = 3,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          set_i,
  input  logic [SRC_W-1:0]              set_src_i,
  input  logic                          clr_i,
  input  logic [SRC_W-1:0]              clr_src_i,
  input  logic [NUM_SRC-1:0][PRI_W-1:0] pri_i,
  output logic [NUM_SRC-1:0]            isr_o,
  output logic                          svc_any_o,
  output pri_t                          svc_lvl_o
);
  logic [NUM_SRC-1:0] isr_q, set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (set_i && set_src_i == SRC_W'(i)) set_vec[i] = 1'b1;
      if (clr_i && clr_src_i == SRC_W'(i)) clr_vec[i] = 1'b1;
    end
  end

  // Clear wins over set for the same source in one cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q | set_vec) & ~clr_vec;
  end

  // Most urgent level currently in service.
  always_comb begin
    svc_lvl_o = PRI_LOW;
    for (int i = 0; i < NUM_SRC; i++)
      if (isr_q[i] && pri_i[i] < svc_lvl_o) svc_lvl_o = pri_i[i];
  end

  assign svc_any_o = |isr_q;
  assign isr_o     = isr_q;

  assert_ack_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !(clr_i && clr_src_i == set_src_i)) |=> isr_q[$past(set_src_i)]);

  assert_eoi_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && clr_src_i < SRC_W'(NUM_SRC)) |=> !isr_q[$past(clr_src_i)]);
endmodule

// File: rtl/ipm_arbiter.sv
module ipm_arbiter
  import ipm_pkg::*;
#(
  parameter int NUM_SRC = 3,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SRC-1:0]            req_i,
  input  logic [NUM_SRC-1:0]            mask_i,
  input  logic [NUM_SRC-1:0][PRI_W-1:0] pri_i,
  input  pri_t                          thr_i,
  input  logic                          svc_any_i,
  input  pri_t                          svc_lvl_i,
  output logic                          valid_o,
  output logic [SRC_W-1:0]              src_o
);
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] grant;
  pri_t               best;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    logic pass_thr, pass_svc;
    assign pass_thr = (pri_i[g] <= thr_i);
    assign pass_svc = !svc_any_i || (pri_i[g] < svc_lvl_i);
    assign elig[g]  = req_i[g] && !mask_i[g] && pass_thr && pass_svc;
  end

  // Strict compare keeps the lower index on ties.
  always_comb begin
    valid_o = 1'b0;
    src_o   = '0;
    best    = PRI_LOW;
    grant   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!valid_o || pri_i[i] < best)) begin
        valid_o = 1'b1;
        src_o   = SRC_W'(i);
        best    = pri_i[i];
        grant   = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assert_grant_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (valid_o == (grant != '0)));

  assert_grant_thr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pri_i[src_o] <= thr_i) && !mask_i[src_o] && req_i[src_o]);

  assert_grant_svc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && svc_any_i) |-> (pri_i[src_o] < svc_lvl_i));
endmodule

// File: rtl/ipm_ctrl.sv
module ipm_ctrl
  import ipm_pkg::*;
#(
  parameter int NUM_SRC = 3,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_we_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               ack_i,
  input  logic               eoi_i,
  input  logic [SRC_W-1:0]   eoi_src_i,
  output logic               irq_o,
  output logic [SRC_W-1:0]   irq_src_o
);
  // Address map holds at most four control registers below ADDR_MASK.
  logic [NUM_SRC-1:0][PRI_W-1:0] pri;
  logic [NUM_SRC-1:0]            mask, isr;
  pri_t                          thr, svc_lvl;
  logic                          svc_any, win_valid;
  logic [SRC_W-1:0]              win_src;

  ipm_regs #(.NUM_SRC(NUM_SRC)) i_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .isr_i(isr), .rdata_o(reg_rdata_o),
    .pri_o(pri), .mask_o(mask), .thr_o(thr)
  );

  ipm_inservice #(.NUM_SRC(NUM_SRC)) i_insvc (
    .clk_i, .rst_ni,
    .set_i(ack_i && irq_o), .set_src_i(irq_src_o),
    .clr_i(eoi_i), .clr_src_i(eoi_src_i),
    .pri_i(pri), .isr_o(isr),
    .svc_any_o(svc_any), .svc_lvl_o(svc_lvl)
  );

  ipm_arbiter #(.NUM_SRC(NUM_SRC)) i_arb (
    .clk_i, .rst_ni,
    .req_i, .mask_i(mask), .pri_i(pri), .thr_i(thr),
    .svc_any_i(svc_any), .svc_lvl_i(svc_lvl),
    .valid_o(win_valid), .src_o(win_src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      irq_src_o <= '0;
    end else begin
      irq_o     <= win_valid;
      irq_src_o <= win_valid ? win_src : '0;
    end
  end

  assert_src_idle_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_src_o == '0));

  assert_src_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_src_o < SRC_W'(NUM_SRC)));
endmodule

// File: tb/test_ipm_ctrl.sv
module test_ipm_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  req = '0, addr = '0;
  logic        we = 0, ack = 0, eoi = 0;
  logic [15:0] wdata = '0, rdata;
  logic [1:0]  eoi_src = '0, irq_src;
  logic        irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  ipm_ctrl i_ipm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_i(ack), .eoi_i(eoi), .eoi_src_i(eoi_src),
    .irq_o(irq), .irq_src_o(irq_src)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic settle(); @(negedge clk); endtask

  task automatic chk_irq(string tag, logic e_irq, logic [1:0] e_src);
    chk({tag, " irq"}, int'(irq), int'(e_irq));
    chk({tag, " src"}, int'(irq_src), int'(e_src));
  endtask

  task automatic clean();
    @(negedge clk); req = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); eoi = 1; eoi_src = 2'(i);
    end
    @(negedge clk); eoi = 0;
    for (int i = 0; i < 3; i++) wr(3'(i), 16'h0007);
    wr(3'd5, 16'h0007);
    settle();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(3'd5, d); chk("R1 thr", d, 16'h0007);
    for (int i = 0; i < 3; i++) begin rd(3'(i), d); chk("R1 ctrl", d, 16'h0007); end
    rd(3'd4, d); chk("R1 mask", d, 0);
    rd(3'd6, d); chk("R1 isr", d, 0);
    chk("R1 irq", int'(irq), 0);
  endtask

  task automatic t_thr_reg();
    logic [15:0] d;
    wr(3'd5, 16'hFFFF); rd(3'd5, d); chk("R2 all ones", d, 16'h0007);
    wr(3'd5, 16'hFFF9); rd(3'd5, d); chk("R2 low bits", d, 16'h0001);
    wr(3'd5, 16'h0007);
  endtask

  task automatic t_threshold();
    wr(3'd5, 16'h0003);
    wr(3'd0, 16'h0004);
    @(negedge clk); req = 3'b001; settle();
    chk_irq("R3 above", 0, 0);
    wr(3'd0, 16'h0003); settle();
    chk_irq("R3 equal", 1, 0);
    clean();
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wr(3'd1, 16'h0008 | 16'h0002);
    rd(3'd4, d); chk("R4 mirror to shared", d, 16'h0002);
    @(negedge clk); req = 3'b010; settle();
    chk_irq("R4 masked", 0, 0);
    wr(3'd4, 16'h0000);
    rd(3'd1, d); chk("R4 mirror to ctrl", d, 16'h0002);
    settle(); chk_irq("R4 unmasked", 1, 1);
    wr(3'd4, 16'h0004);
    rd(3'd2, d); chk("R4 shared sets ctrl", d, 16'h000F);
    clean();
  endtask

  task automatic t_priority();
    wr(3'd0, 16'h0005); wr(3'd1, 16'h0002); wr(3'd2, 16'h0004);
    @(negedge clk); req = 3'b111; settle();
    chk_irq("R5 lowest number", 1, 1);
    wr(3'd2, 16'h0001); settle();
    chk_irq("R5 new winner", 1, 2);
    clean();
  endtask

  task automatic t_tie();
    for (int i = 0; i < 3; i++) wr(3'(i), 16'h0003);
    @(negedge clk); req = 3'b111; settle();
    chk_irq("R6 tie all", 1, 0);
    @(negedge clk); req = 3'b110; settle();
    chk_irq("R6 tie dma", 1, 1);
    clean();
  endtask

  task automatic t_ack_eoi();
    logic [15:0] d;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    rd(3'd6, d); chk("R7 ack idle", d, 0);
    wr(3'd2, 16'h0002);
    @(negedge clk); req = 3'b100; settle();
    chk_irq("R7 pre", 1, 2);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    rd(3'd6, d); chk("R7 isr set", d, 16'h0004);
    settle(); chk_irq("R9 self block", 0, 0);
    @(negedge clk); eoi = 1; eoi_src = 2'd2;
    @(negedge clk); eoi = 0;
    rd(3'd6, d); chk("R8 isr clear", d, 0);
    clean();
  endtask

  task automatic t_nest();
    logic [15:0] d;
    wr(3'd1, 16'h0002); wr(3'd0, 16'h0002);
    @(negedge clk); req = 3'b010; settle();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0; req = 3'b001;
    rd(3'd6, d); chk("R9 isr dma0", d, 16'h0002);
    settle(); settle();
    chk_irq("R9 equal blocked", 0, 0);
    wr(3'd0, 16'h0001); settle();
    chk_irq("R9 more urgent", 1, 0);
    @(negedge clk); eoi = 1; eoi_src = 2'd1;
    @(negedge clk); eoi = 0;
    rd(3'd6, d); chk("R8 nest clear", d, 0);
    clean();
  endtask

  task automatic t_timing();
    wr(3'd1, 16'h0004);
    @(negedge clk); req = 3'b010;
    #1 chk_irq("R10 before edge", 0, 0);
    settle(); chk_irq("R10 after edge", 1, 1);
    @(negedge clk); req = 3'b000;
    #1 chk("R10 hold", int'(irq), 1);
    settle(); chk_irq("R10 drop", 0, 0);
    clean();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        settle();
        t_reset();
        t_thr_reg();
        t_threshold();
        t_mask();
        t_priority();
        t_tie();
        t_ack_eoi();
        t_nest();
        t_timing();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule